// File: doc/BRIEF.md
# Overlapped-Scan Signed-Digit Recoder

This combinational block takes a signed two's complement multiplier operand and rewrites it as a vector of signed digits in radix 2^k. The group size k is a parameter and may be any value of at least 1. The same design therefore covers several cases: the 2-bit scan (k=1), the common radix-4 scheme with a 3-bit scan (k=2), the 5-bit scan (k=4), and wider groupings.

The operand is read through windows of k+1 bits. Each window shares exactly one bit with the window below it. The lowest window takes an implied zero as its shared bit. When the operand width is not a multiple of k, the operand is sign-extended until the top window is full.

Each digit is presented as a negative flag, a k-bit unsigned magnitude and a zero flag. A partial-product generator downstream can then choose a multiple of the multiplicand, negate it, or skip it. Forming and summing the partial products is the job of the surrounding multiplier.

Top module: `booth_scan_recoder`

## Requirements
- R1: Digit 0 is taken from operand bits k-1..0 together with an implied 0 below bit 0. Digit g is taken from window bits g·k+k..g·k, and its lowest bit is the highest bit of the window below.
- R2: For a window w[k:0], the digit value is −2^(k−1)·w[k] + Σ_{i=0}^{k−2} 2^i·w[i+1] + w[0].
- R3: The magnitude of every digit is at most 2^(k−1). The value 2^(k−1) itself is reachable and is represented.
- R4: Σ_g digit_g·2^(g·k) equals the operand read as a two's complement integer, for every operand value.
- R5: When WIDTH is not a multiple of GRP, the bits above the operand repeat its sign bit. The top digit takes its value from these sign bits.
- R6: Digit g sits at `dig_neg_o[g]` and `dig_mag_o[g*GRP +: GRP]`. The negative flag is 1 exactly when the digit is below zero. The magnitude is the absolute value. A zero digit is never flagged negative.
- R7: `dig_zero_o[g]` is 1 exactly when digit g is zero, that is, when its window is all zeros or all ones.
- R8: With k=1 every digit lies in {−1,0,1}. With k=2 every digit lies in {−2,…,2}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | WIDTH | Two's complement operand to recode |
| dig_neg_o | output | NDIG | Per-digit negative flag, digit g at bit g |
| dig_mag_o | output | NDIG*GRP | Per-digit unsigned magnitude, digit g at bits g*GRP+GRP-1..g*GRP |
| dig_zero_o | output | NDIG | Per-digit zero flag |

NDIG = ceil(WIDTH/GRP).

## Verification
The bench builds six copies of the block, with (WIDTH, GRP) set to (8,1), (8,2), (10,3), (12,4), (13,5) and (7,3). Every copy is driven through its complete operand space.

The pairs with k=1 and k=2 cover the two narrow digit sets. The pairs with k=3 to 5 reach the wider radices, where the magnitude ±2^(k−1) appears. Three of the pairs have a width that is not a multiple of k, so the sign-extension path into the top digit is exercised. Because the operand space is swept in full, the most negative operand and every all-ones or all-zeros window are included.

// File: rtl/booth_scan_recoder.sv
module booth_scan_recoder #(
  parameter int WIDTH = 16,
  parameter int GRP = 2,
  localparam int NDIG = (WIDTH + GRP - 1) / GRP
) (
  input  logic [WIDTH-1:0]    operand_i,
  output logic [NDIG-1:0]     dig_neg_o,
  output logic [NDIG*GRP-1:0] dig_mag_o,
  output logic [NDIG-1:0]     dig_zero_o
);

  localparam int EXTW = NDIG * GRP + 1;

  logic [EXTW-1:0] scan;

  assign scan[0] = 1'b0;

  for (genvar i = 0; i < EXTW - 1; i++) begin : g_ext
    if (i < WIDTH) begin : g_in
      assign scan[i+1] = operand_i[i];
    end else begin : g_sx
      assign scan[i+1] = operand_i[WIDTH-1];
    end
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [GRP:0]        win;
    logic signed [GRP:0] val;
    logic [GRP-1:0]      absv;

    assign win  = scan[g*GRP +: GRP+1];
    assign val  = $signed({win[GRP], win[GRP:1]}) + $signed({{GRP{1'b0}}, win[0]});
    assign absv = val[GRP] ? GRP'(-val) : GRP'(val);

    assign dig_neg_o[g]            = val[GRP];
    assign dig_mag_o[g*GRP +: GRP] = absv;
    assign dig_zero_o[g]           = (val == '0);
  end

endmodule

// File: rtl/booth_scan_recoder_chk.sv
module booth_scan_recoder_chk #(
  parameter int WIDTH = 16,
  parameter int GRP = 2,
  parameter int NDIG = 8
) (
  input logic [WIDTH-1:0]    operand_i,
  input logic [NDIG-1:0]     dig_neg_o,
  input logic [NDIG*GRP-1:0] dig_mag_o,
  input logic [NDIG-1:0]     dig_zero_o
);

  always_comb begin
    longint acc;
    longint mg;
    acc = 0;
    mg  = 0;
    if (!$isunknown({operand_i, dig_neg_o, dig_mag_o, dig_zero_o})) begin
      for (int g = 0; g < NDIG; g++) begin
        mg = longint'(dig_mag_o[g*GRP +: GRP]);
        p_digit_range_r3: assert (mg <= (64'sd1 <<< (GRP - 1)));
        p_zero_flag_r7: assert (dig_zero_o[g] == (mg == 0));
        p_zero_not_neg_r6: assert (!(dig_neg_o[g] && dig_zero_o[g]));
        acc = acc + (dig_neg_o[g] ? -mg : mg) * (64'sd1 <<< (g * GRP));
      end
      p_value_exact_r4: assert (acc == longint'($signed(operand_i)));
    end
  end

endmodule

bind booth_scan_recoder booth_scan_recoder_chk #(
  .WIDTH(WIDTH), .GRP(GRP), .NDIG(NDIG)
) u_chk (.*);

// File: tb/test_booth_scan_recoder.sv
module recoder_lane #(
  parameter int W = 8,
  parameter int K = 2
) (
  input  logic clk,
  output logic done,
  output int   checks,
  output int   errors
);
  localparam int G = (W + K - 1) / K;

  typedef struct {
    longint          v;
    logic [G-1:0]    neg;
    logic [G*K-1:0]  mag;
    logic [G-1:0]    zero;
  } item_t;

  logic [W-1:0]   opnd;
  logic [G-1:0]   neg_w;
  logic [G*K-1:0] mag_w;
  logic [G-1:0]   zero_w;
  item_t          q[$];
  item_t          e;

  booth_scan_recoder #(.WIDTH(W), .GRP(K)) i_booth_scan_recoder (
    .operand_i(opnd), .dig_neg_o(neg_w), .dig_mag_o(mag_w), .dig_zero_o(zero_w)
  );

  function automatic longint rnd_shift(longint v, int g);
    if (g == 0) return v;
    return (v + (64'sd1 <<< (g * K - 1))) >>> (g * K);
  endfunction

  function automatic item_t expect_of(longint v);
    item_t  it;
    longint d;
    it.v = v;
    it.neg = '0;
    it.mag = '0;
    it.zero = '0;
    for (int g = 0; g < G; g++) begin
      d = rnd_shift(v, g) - (rnd_shift(v, g + 1) <<< K);
      it.neg[g] = (d < 0);
      it.mag[g*K +: K] = K'(d < 0 ? -d : d);
      it.zero[g] = (d == 0);
    end
    return it;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp, input longint v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s lane W=%0d K=%0d operand=%0d actual=%0d expected=%0d", req, W, K, v, act, exp);
    end
  endtask

  initial begin
    done = 1'b0;
    checks = 0;
    errors = 0;
    opnd = '0;
    for (int i = 0; i < (1 << W); i++) begin
      @(posedge clk);
      opnd <= W'(i);
      q.push_back(expect_of(longint'($signed(W'(i)))));
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  always @(negedge clk) begin
    if (q.size() > 0) begin
      longint sum;
      longint m;
      bit     rng_ok;
      bit     sgn_ok;
      e = q.pop_front();
      chk({neg_w[0], mag_w[K-1:0]} == {e.neg[0], e.mag[K-1:0]}, "R1",
          longint'({neg_w[0], mag_w[K-1:0]}), longint'({e.neg[0], e.mag[K-1:0]}), e.v);
      if (G > 1) begin
        if (W % K != 0)
          chk({neg_w[G-1], mag_w[(G-1)*K +: K]} == {e.neg[G-1], e.mag[(G-1)*K +: K]}, "R5",
              longint'({neg_w[G-1], mag_w[(G-1)*K +: K]}),
              longint'({e.neg[G-1], e.mag[(G-1)*K +: K]}), e.v);
        chk(neg_w == e.neg && mag_w == e.mag, "R2", longint'(mag_w), longint'(e.mag), e.v);
      end
      chk(zero_w == e.zero, "R7", longint'(zero_w), longint'(e.zero), e.v);
      sum = 0;
      rng_ok = 1'b1;
      sgn_ok = 1'b1;
      for (int g = 0; g < G; g++) begin
        m = longint'(mag_w[g*K +: K]);
        if (m > (64'sd1 <<< (K - 1))) rng_ok = 1'b0;
        if (neg_w[g] && m == 0) sgn_ok = 1'b0;
        sum = sum + (neg_w[g] ? -m : m) * (64'sd1 <<< (g * K));
      end
      chk(rng_ok, (K <= 2) ? "R8" : "R3", longint'(mag_w), 64'sd1 <<< (K - 1), e.v);
      chk(sgn_ok, "R6", longint'(neg_w), longint'(e.neg), e.v);
      chk(sum == e.v, "R4", sum, e.v, e.v);
    end
  end
endmodule

module test_booth_scan_recoder;
  localparam int NL = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [NL-1:0] dn;
  int ck[NL];
  int er[NL];

  recoder_lane #(.W(8),  .K(1)) u_l0 (.clk(clk), .done(dn[0]), .checks(ck[0]), .errors(er[0]));
  recoder_lane #(.W(8),  .K(2)) u_l1 (.clk(clk), .done(dn[1]), .checks(ck[1]), .errors(er[1]));
  recoder_lane #(.W(10), .K(3)) u_l2 (.clk(clk), .done(dn[2]), .checks(ck[2]), .errors(er[2]));
  recoder_lane #(.W(12), .K(4)) u_l3 (.clk(clk), .done(dn[3]), .checks(ck[3]), .errors(er[3]));
  recoder_lane #(.W(13), .K(5)) u_l4 (.clk(clk), .done(dn[4]), .checks(ck[4]), .errors(er[4]));
  recoder_lane #(.W(7),  .K(3)) u_l5 (.clk(clk), .done(dn[5]), .checks(ck[5]), .errors(er[5]));

  initial begin
    int cyc;
    int tc;
    int te;
    cyc = 0;
    while (!(&dn) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    #1;
    tc = 0;
    te = 0;
    for (int i = 0; i < NL; i++) begin
      tc += ck[i];
      te += er[i];
    end
    if (!(&dn)) begin
      tc++;
      te++;
      $display("FAIL watchdog: lanes done=%b expected=%b", dn, {NL{1'b1}});
    end
    $display("Simulation finished: %0d checks, %0d errors", tc, te);
    $finish;
  end
endmodule